// File: doc/BRIEF.md
# Run-time loadable programmable logic array

This block evaluates several Boolean functions of a small input vector as shared sums of products. Its AND plane holds one row per product term, and each row gives every input a two-bit literal code. Its OR plane holds one row per output, with one bit per product term. Both planes are registers that a simple write port loads at run time. Because the terms are general products and not minterms, one minimized term can feed any number of outputs.

The input-to-output path is purely combinational. Only the configuration is clocked. After a synchronous reset every entry is cleared. Every OR row is then empty, so every output reads 0 until software loads the planes.

Top module: `cfg_pla`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears both planes, after which every output is 0 for every input value.
- R2: In an AND row, bits [2i+1:2i] hold the literal code for input i. Code 2'b01 uses the input true and code 2'b10 uses it complemented.
- R3: Code 2'b00 leaves its input out of the term, and a term whose codes are all 2'b00 evaluates to 1.
- R4: Code 2'b11 in any field forces that product term to 0 whatever the inputs.
- R5: Bit k of OR row j set to 1 adds term k to output j's OR. An output with no selected term that is 1 reads 0.
- R6: One product term may be selected by several outputs at once, and each of those outputs sees it.
- R7: A write with cfg_we high is captured at the rising edge. The outputs show it only after that edge, and only the addressed row changes.
- R8: A write whose row index is not below the row count of the selected plane (N_TERM for AND, N_OUT for OR) changes nothing.
- R9: The outputs follow changes on pla_in with no clock edge in between.
- R10: cfg_plane 0 selects the AND plane and 1 selects the OR plane. An OR write uses cfg_data[N_TERM-1:0], and higher data bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset that clears both planes |
| cfg_we | input | 1 | Write strobe for one configuration row |
| cfg_plane | input | 1 | Plane select: 0 for the AND plane, 1 for the OR plane |
| cfg_row | input | ROW_W (3) | Row index within the selected plane |
| cfg_data | input | DATA_W (6) | Row contents: literal codes for AND, term select bits for OR |
| pla_in | input | N_IN (3) | Function inputs |
| pla_out | output | N_OUT (4) | Evaluated function outputs |

## Verification
The assertions assume that the inputs are steady when a write to an unused row lands. They also assume that the write strobe, plane select and row index are driven at known values away from the edge. The bench changes configuration signals and function inputs only at falling edges, and during each out-of-range write it holds pla_in fixed. A row-write assertion looks one cycle ahead. Because of this, the bench never performs a reset in the cycle that follows a write.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic [1:0] {
        LIT_ABSENT = 2'b00,
        LIT_TRUE   = 2'b01,
        LIT_COMP   = 2'b10,
        LIT_KILL   = 2'b11
    } lit_code_e;

    typedef enum logic {
        PLANE_AND = 1'b0,
        PLANE_OR  = 1'b1
    } plane_sel_e;

    // Contribution of one literal to its product term.
    function automatic logic lit_pass(input logic [1:0] code, input logic x);
        logic r;
        case (lit_code_e'(code))
            LIT_TRUE: r = x;
            LIT_COMP: r = ~x;
            LIT_KILL: r = 1'b0;
            default:  r = 1'b1;
        endcase
        return r;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pla_cfg_decode.sv
module pla_cfg_decode #(
    parameter int N_TERM = 5,
    parameter int N_OUT  = 4,
    parameter int ROW_W  = 3
) (
    input  logic             we,
    input  logic             plane,
    input  logic [ROW_W-1:0] row,
    output logic             and_we,
    output logic             or_we
);
    import pla_pkg::*;

    logic and_row_ok;
    logic or_row_ok;

    always_comb begin
        and_row_ok = (int'(row) < N_TERM);
        or_row_ok  = (int'(row) < N_OUT);
        and_we     = we && (plane_sel_e'(plane) == PLANE_AND) && and_row_ok;
        or_we      = we && (plane_sel_e'(plane) == PLANE_OR)  && or_row_ok;
    end

endmodule

// File: rtl/pla_term_plane.sv
module pla_term_plane #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 5,
    parameter int ROW_W  = 3,
    localparam int ROW_BITS = 2 * N_IN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ROW_W-1:0]    wr_row,
    input  logic [ROW_BITS-1:0] wr_data,
    input  logic [N_IN-1:0]     in_vec,
    output logic [N_TERM-1:0]   term_vec
);
    import pla_pkg::*;

    typedef struct packed {
        logic [N_TERM-1:0][ROW_BITS-1:0] row;
    } and_state_t;

    and_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < N_TERM; r++) begin
            if (wr_en && (wr_row == ROW_W'(r))) begin
                st_d.row[r] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [N_TERM-1:0][N_IN-1:0] lit_ok;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            assign lit_ok[t][i] = lit_pass(st_q.row[t][2*i +: 2], in_vec[i]);
        end
        assign term_vec[t] = &lit_ok[t];
    end

endmodule

// File: rtl/pla_sum_plane.sv
module pla_sum_plane #(
    parameter int N_TERM = 5,
    parameter int N_OUT  = 4,
    parameter int ROW_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [N_TERM-1:0] wr_data,
    input  logic [N_TERM-1:0] term_vec,
    output logic [N_OUT-1:0]  out_vec
);

    typedef struct packed {
        logic [N_OUT-1:0][N_TERM-1:0] row;
    } or_state_t;

    or_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < N_OUT; r++) begin
            if (wr_en && (wr_row == ROW_W'(r))) begin
                st_d.row[r] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        assign out_vec[o] = |(st_q.row[o] & term_vec);
    end

endmodule

// File: rtl/cfg_pla.sv
module cfg_pla #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 5,
    parameter int N_OUT  = 4,
    localparam int ROW_W  = (pla_pkg::max_int(N_TERM, N_OUT) > 1) ?
                            $clog2(pla_pkg::max_int(N_TERM, N_OUT)) : 1,
    localparam int DATA_W = pla_pkg::max_int(2 * N_IN, N_TERM)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_plane,
    input  logic [ROW_W-1:0]  cfg_row,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic [N_IN-1:0]   pla_in,
    output logic [N_OUT-1:0]  pla_out
);

    logic              and_we;
    logic              or_we;
    logic [N_TERM-1:0] term_vec;

    pla_cfg_decode #(
        .N_TERM (N_TERM),
        .N_OUT  (N_OUT),
        .ROW_W  (ROW_W)
    ) u_dec (
        .we     (cfg_we),
        .plane  (cfg_plane),
        .row    (cfg_row),
        .and_we (and_we),
        .or_we  (or_we)
    );

    pla_term_plane #(
        .N_IN   (N_IN),
        .N_TERM (N_TERM),
        .ROW_W  (ROW_W)
    ) u_and (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (and_we),
        .wr_row   (cfg_row),
        .wr_data  (cfg_data[2*N_IN-1:0]),
        .in_vec   (pla_in),
        .term_vec (term_vec)
    );

    pla_sum_plane #(
        .N_TERM (N_TERM),
        .N_OUT  (N_OUT),
        .ROW_W  (ROW_W)
    ) u_or (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (or_we),
        .wr_row   (cfg_row),
        .wr_data  (cfg_data[N_TERM-1:0]),
        .term_vec (term_vec),
        .out_vec  (pla_out)
    );

endmodule

// File: rtl/pla_checker.sv
module pla_checker #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 5,
    parameter int N_OUT  = 4,
    parameter int ROW_W  = 3,
    parameter int DATA_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic              cfg_plane,
    input logic [ROW_W-1:0]  cfg_row,
    input logic [DATA_W-1:0] cfg_data,
    input logic [N_IN-1:0]   pla_in,
    input logic [N_TERM-1:0] term_vec,
    input logic [N_OUT-1:0]  pla_out
);

    logic has_kill;
    logic all_absent;
    logic bad_row;

    always_comb begin
        has_kill = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (cfg_data[2*i +: 2] == 2'b11) has_kill = 1'b1;
        end
        all_absent = (cfg_data[2*N_IN-1:0] == '0);
        bad_row    = cfg_plane ? (int'(cfg_row) >= N_OUT) : (int'(cfg_row) >= N_TERM);
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_t
        // R4: a kill code written into a row switches that term off
        p_term_off_r4: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && !cfg_plane && cfg_row == ROW_W'(t) && has_kill) |=> !term_vec[t]);
        // R3: an all-absent row makes the term constant 1
        p_term_on_r3: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && !cfg_plane && cfg_row == ROW_W'(t) && all_absent) |=> term_vec[t]);
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_o
        // R5: an empty OR row gives 0 on its output
        p_or_clear_r5: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && cfg_plane && cfg_row == ROW_W'(o) && cfg_data[N_TERM-1:0] == '0)
            |=> !pla_out[o]);
    end

    // R5: no active term means no active output
    p_no_term_r5: assert property (@(posedge clk) disable iff (rst)
        (term_vec == '0) |-> (pla_out == '0));

    // R8: an out-of-range write leaves the outputs alone while the inputs hold
    p_bad_row_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && bad_row) |=> (!$stable(pla_in) || $stable(pla_out)));

endmodule

bind cfg_pla pla_checker #(
    .N_IN   (N_IN),
    .N_TERM (N_TERM),
    .N_OUT  (N_OUT),
    .ROW_W  (ROW_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_plane (cfg_plane),
    .cfg_row   (cfg_row),
    .cfg_data  (cfg_data),
    .pla_in    (pla_in),
    .term_vec  (term_vec),
    .pla_out   (pla_out)
);

// File: tb/tb_cfg_pla.sv
`timescale 1ns/1ps
module tb_cfg_pla;

    localparam int NI = 3;
    localparam int NT = 5;
    localparam int NO = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic          cfg_plane = 1'b0;
    logic [2:0]    cfg_row = '0;
    logic [5:0]    cfg_data = '0;
    logic [NI-1:0] pla_in = '0;
    logic [NO-1:0] pla_out;

    cfg_pla dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_plane (cfg_plane),
        .cfg_row   (cfg_row),
        .cfg_data  (cfg_data),
        .pla_in    (pla_in),
        .pla_out   (pla_out)
    );

    always #10 clk = ~clk;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    logic [5:0] and_m [NT];
    logic [4:0] or_m  [NO];

    function automatic logic [NO-1:0] model(input logic [NI-1:0] x);
        logic [NT-1:0] tv;
        logic [NO-1:0] ov;
        for (int t = 0; t < NT; t++) begin
            tv[t] = 1'b1;
            for (int i = 0; i < NI; i++) begin
                case (and_m[t][2*i +: 2])
                    2'b01:   tv[t] = tv[t] & x[i];
                    2'b10:   tv[t] = tv[t] & ~x[i];
                    2'b11:   tv[t] = 1'b0;
                    default: ;
                endcase
            end
        end
        for (int o = 0; o < NO; o++) ov[o] = |(or_m[o] & tv);
        return ov;
    endfunction

    task automatic chk(input string req, input logic [NO-1:0] got, input logic [NO-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%b exp=%b", req, got, exp);
        end
    endtask

    task automatic clear_model();
        for (int t = 0; t < NT; t++) and_m[t] = '0;
        for (int o = 0; o < NO; o++) or_m[o] = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        clear_model();
    endtask

    task automatic wr(input logic plane, input logic [2:0] row, input logic [5:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_plane = plane; cfg_row = row; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!plane && row < NT) and_m[row] = data;
        if (plane && row < NO)  or_m[row]  = data[4:0];
    endtask

    task automatic sweep(input string req);
        for (int x = 0; x < (1 << NI); x++) begin
            pla_in = NI'(x);
            #2;
            chk(req, pla_out, model(NI'(x)));
        end
    endtask

    // R1: cleared state gives all-zero outputs
    task automatic t_reset();
        do_reset();
        for (int x = 0; x < (1 << NI); x++) begin
            pla_in = NI'(x);
            #2;
            chk("R1 after reset", pla_out, '0);
        end
    endtask

    // R2 R5 R6 R9: shared minimized terms
    task automatic t_shared();
        do_reset();
        wr(1'b0, 3'd0, 6'b001001);   // x0 & ~x1
        wr(1'b0, 3'd1, 6'b010000);   // x2
        wr(1'b0, 3'd2, 6'b010110);   // ~x0 & x1 & x2
        wr(1'b0, 3'd3, 6'b100000);   // ~x2
        wr(1'b0, 3'd4, 6'b000100);   // x1
        wr(1'b1, 3'd0, 6'b000011);
        wr(1'b1, 3'd1, 6'b000110);
        wr(1'b1, 3'd2, 6'b011000);
        wr(1'b1, 3'd3, 6'b010101);
        sweep("R2 R5 R9 sweep");
        pla_in = 3'b001; #2;
        chk("R6 shared x=001", pla_out, 4'b1101);
        pla_in = 3'b110; #2;
        chk("R6 shared x=110", pla_out, 4'b1111);
        pla_in = 3'b100; #2;
        chk("R2 literals x=100", pla_out, 4'b0011);
    endtask

    // R3: all-absent term is constant 1
    task automatic t_absent();
        do_reset();
        wr(1'b1, 3'd1, 6'b000100);
        for (int x = 0; x < (1 << NI); x++) begin
            pla_in = NI'(x);
            #2;
            chk("R3 absent term", pla_out, 4'b0010);
        end
    endtask

    // R4: kill code disables the term
    task automatic t_kill();
        do_reset();
        wr(1'b0, 3'd2, 6'b001100);
        wr(1'b0, 3'd3, 6'b110101);
        wr(1'b1, 3'd1, 6'b001100);
        for (int x = 0; x < (1 << NI); x++) begin
            pla_in = NI'(x);
            #2;
            chk("R4 forced false", pla_out, 4'b0000);
        end
        wr(1'b1, 3'd0, 6'b000001);
        sweep("R4 other term live");
    endtask

    // R8: out-of-range rows are ignored
    task automatic t_bad_row();
        do_reset();
        wr(1'b0, 3'd0, 6'b000001);   // x0
        wr(1'b1, 3'd0, 6'b000001);
        wr(1'b1, 3'd2, 6'b000001);
        pla_in = 3'b011;
        wr(1'b0, 3'd5, 6'b111111);
        wr(1'b0, 3'd7, 6'b111111);
        wr(1'b1, 3'd4, 6'b111111);
        wr(1'b1, 3'd7, 6'b111111);
        #2;
        chk("R8 bad rows x=011", pla_out, 4'b0101);
        sweep("R8 bad rows sweep");
    endtask

    // R10: plane select and ignored high OR bits
    task automatic t_plane();
        do_reset();
        wr(1'b1, 3'd0, 6'b100000);
        pla_in = 3'b000; #2;
        chk("R10 high OR bit", pla_out, 4'b0000);
        wr(1'b0, 3'd0, 6'b000010);   // ~x0 on AND plane row 0
        wr(1'b1, 3'd3, 6'b000001);
        pla_in = 3'b000; #2;
        chk("R10 plane select x=000", pla_out, 4'b1000);
        pla_in = 3'b001; #2;
        chk("R10 plane select x=001", pla_out, 4'b0000);
    endtask

    // R7: write visible only after the edge, only for its row
    task automatic t_timing();
        do_reset();
        pla_in = 3'b111;
        @(negedge clk);
        cfg_we = 1'b1; cfg_plane = 1'b1; cfg_row = 3'd2; cfg_data = 6'b000001;
        #2;
        chk("R7 before edge", pla_out, 4'b0000);
        @(negedge clk);
        cfg_we = 1'b0;
        or_m[2] = 5'b00001;
        #2;
        chk("R7 after edge", pla_out, 4'b0100);
        sweep("R7 single row");
    endtask

    initial begin
        clear_model();
        t_reset();
        t_shared();
        t_absent();
        t_kill();
        t_bad_row();
        t_plane();
        t_timing();
        wr(1'b1, 3'd0, 6'b011111);
        do_reset();
        pla_in = 3'b101; #2;
        chk("R1 reset after config", pla_out, 4'b0000);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog got=running exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule